// File: doc/BRIEF.md
# Thread-Block Dispatcher with Per-Core Resource Limits

This block hands the thread blocks of a compute grid to a row of compute cores, one whole block at a time. A launch supplies the grid size and the footprint of one block: its thread count, the registers each thread needs, and its shared-memory bytes. For every core the dispatcher keeps a ledger of threads, registers and shared memory in use, together with the number of blocks running there. A block may only go to a core where all four budgets still hold once the block is added.

Blocks leave in increasing id order, at most one per cycle. Each block goes to the eligible core that has the fewest blocks running, so a grid spreads breadth-first across the cores. A core reports that one of its blocks has finished with a single-cycle retire pulse. Only then does that block's whole footprint return to the core's budgets. When the last block has been handed out and every core has gone quiet, the grid is over and the done flag rises. The next launch is taken only at that point.

Top module: `blk_launch_sched`

## Requirements
- R1: After reset `grid_done_o` is 1, `issue_valid_o` is 0 and every core ledger is empty.
- R2: A `launch_i` pulse seen while `grid_done_o` is 1 captures the grid size and the per-block footprint, and block ids restart at 0. A `launch_i` pulse seen while a grid is in progress is ignored: neither the id sequence nor the footprint changes.
- R3: At most one block is issued per cycle. Within a grid the ids on `issue_id_o` are 0, 1, 2, … in order, with none skipped or repeated.
- R4: A block goes only to a core where, once the block is added, all of the following hold: threads ≤ MAX_THREADS, registers (threads × registers per thread) ≤ MAX_REGS, shared bytes ≤ MAX_SMEM, and running blocks ≤ MAX_SLOTS.
- R5: Among the eligible cores, the block goes to the one with the fewest running blocks. On a tie, the lowest core index wins.
- R6: A pulse on `cta_retire_i[i]` returns one block's threads, registers, shared bytes and slot to core i, and this is visible from the next cycle. A pulse on a core with no running block has no effect.
- R7: An issue to core i and a retire pulse on core i in the same cycle both take effect, so that core's running count stays the same.
- R8: `grid_done_o` falls in the cycle after an accepted launch. It rises again in the cycle after the first cycle in which every block has been issued and no core has a running block. A grid of zero blocks therefore finishes two cycles after its launch is sampled. No block is issued while `grid_done_o` is 1.
- R9: When no core can fit the next block, issue stalls without advancing the id. It resumes with that same id once a retire frees enough room.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| launch_i | input | 1 | Start a grid (taken only while idle) |
| grid_ctas_i | input | ID_W (16) | Number of blocks in the grid |
| cta_threads_i | input | TH_W (11) | Threads per block |
| thread_regs_i | input | RPT_W (8) | Registers per thread |
| cta_smem_i | input | SM_W (15) | Shared-memory bytes per block |
| cta_retire_i | input | NUM_CORES (4) | Per-core pulse: one block on that core has fully finished |
| issue_valid_o | output | 1 | A block is issued this cycle |
| issue_core_o | output | CORE_W (2) | Core receiving the block |
| issue_id_o | output | ID_W (16) | Id of the block issued |
| grid_done_o | output | 1 | No grid in progress |

## Verification
The checker tests a set of rules on every cycle. An issued block always fits its target core, and no eligible core is less loaded than the chosen one or ties with it at a lower index. Ids step by one between back-to-back issues, no core goes past its slot budget, a lone retire lowers a core's count by exactly one, and nothing is issued while the done flag is high. Some behaviour can only be shown by the bench's scenarios, which run a behavioural model against the outputs. This covers stalls where the thread, register, shared-memory or slot budget is exhausted and later released, ignored relaunches and stray retire pulses, zero-size grids, and the exact cycle at which the done flag rises.

// File: rtl/blk_sched_pkg.sv
`timescale 1ns/1ps
package blk_sched_pkg;
   // common width used for all budget arithmetic
   typedef logic [31:0] acc_t;
endpackage

// File: rtl/core_ledger.sv
`timescale 1ns/1ps
// Per-core budget tracker: running blocks plus thread, register and
// shared-memory usage, with a fit test for one more block.
module core_ledger
   import blk_sched_pkg::*;
#(
   parameter int MAX_THREADS = 1024,
   parameter int MAX_REGS    = 16384,
   parameter int MAX_SMEM    = 16384,
   parameter int MAX_SLOTS   = 8,
   localparam int TH_W = $clog2(MAX_THREADS + 1),
   localparam int RG_W = $clog2(MAX_REGS + 1),
   localparam int SM_W = $clog2(MAX_SMEM + 1),
   localparam int SL_W = $clog2(MAX_SLOTS + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            take,
   input  logic            give,
   input  acc_t            need_th,
   input  acc_t            need_rg,
   input  acc_t            need_sm,
   output logic            fits,
   output logic [SL_W-1:0] load
);
   logic [TH_W-1:0] used_th;
   logic [RG_W-1:0] used_rg;
   logic [SM_W-1:0] used_sm;
   logic            rel;

   // a retire on an empty core is dropped
   assign rel = give && (load != '0);

   always_comb begin
      fits = (acc_t'(used_th) + need_th <= acc_t'(MAX_THREADS)) &&
             (acc_t'(used_rg) + need_rg <= acc_t'(MAX_REGS))    &&
             (acc_t'(used_sm) + need_sm <= acc_t'(MAX_SMEM))    &&
             (acc_t'(load) < acc_t'(MAX_SLOTS));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         used_th <= '0;
         used_rg <= '0;
         used_sm <= '0;
         load    <= '0;
      end else begin
         used_th <= TH_W'(acc_t'(used_th) + (take ? need_th : '0) - (rel ? need_th : '0));
         used_rg <= RG_W'(acc_t'(used_rg) + (take ? need_rg : '0) - (rel ? need_rg : '0));
         used_sm <= SM_W'(acc_t'(used_sm) + (take ? need_sm : '0) - (rel ? need_sm : '0));
         load    <= SL_W'(acc_t'(load) + acc_t'(take) - acc_t'(rel));
      end
   end
endmodule

// File: rtl/least_load_pick.sv
`timescale 1ns/1ps
// Picks the eligible core with the smallest load; lowest index on ties.
module least_load_pick #(
   parameter int N     = 4,
   parameter int SL_W  = 4,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]      fits,
   input  logic [N*SL_W-1:0] loads,
   output logic              found,
   output logic [IDX_W-1:0]  idx
);
   if (N == 1) begin : g_single
      assign found = fits[0];
      assign idx   = '0;
   end else begin : g_scan
      logic [SL_W-1:0] best;
      always_comb begin
         found = 1'b0;
         idx   = '0;
         best  = '0;
         for (int i = 0; i < N; i++) begin
            if (fits[i] && (!found || loads[i*SL_W +: SL_W] < best)) begin
               found = 1'b1;
               idx   = IDX_W'(i);
               best  = loads[i*SL_W +: SL_W];
            end
         end
      end
   end
endmodule

// File: rtl/blk_launch_sched.sv
`timescale 1ns/1ps
// Grid block dispatcher: whole-block issue, breadth-first by running
// count, four per-core budgets, release only on block retirement.
module blk_launch_sched
   import blk_sched_pkg::*;
#(
   parameter int NUM_CORES   = 4,
   parameter int MAX_THREADS = 1024,
   parameter int MAX_REGS    = 16384,
   parameter int MAX_SMEM    = 16384,
   parameter int MAX_SLOTS   = 8,
   parameter int ID_W        = 16,
   parameter int RPT_W       = 8,
   localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
   localparam int TH_W   = $clog2(MAX_THREADS + 1),
   localparam int SM_W   = $clog2(MAX_SMEM + 1),
   localparam int SL_W   = $clog2(MAX_SLOTS + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 launch_i,
   input  logic [ID_W-1:0]      grid_ctas_i,
   input  logic [TH_W-1:0]      cta_threads_i,
   input  logic [RPT_W-1:0]     thread_regs_i,
   input  logic [SM_W-1:0]      cta_smem_i,
   input  logic [NUM_CORES-1:0] cta_retire_i,
   output logic                 issue_valid_o,
   output logic [CORE_W-1:0]    issue_core_o,
   output logic [ID_W-1:0]      issue_id_o,
   output logic                 grid_done_o
);
   if (NUM_CORES < 1 || MAX_SLOTS < 1 || MAX_THREADS < 1 ||
       MAX_REGS < 1 || MAX_SMEM < 1 || ID_W < 1 || RPT_W < 1) begin : g_bad_cfg
      $error("blk_launch_sched: every size parameter must be at least 1");
   end

   logic                      busy;
   logic [ID_W-1:0]           next_id;
   logic [ID_W-1:0]           total;
   acc_t                      need_th, need_rg, need_sm;
   logic [NUM_CORES-1:0]      core_fit;
   logic [NUM_CORES*SL_W-1:0] core_load;
   logic                      any_fit;

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      core_ledger #(
         .MAX_THREADS(MAX_THREADS), .MAX_REGS(MAX_REGS),
         .MAX_SMEM(MAX_SMEM), .MAX_SLOTS(MAX_SLOTS)
      ) u_ledger (
         .clk     (clk),
         .rst_n   (rst_n),
         .take    (issue_valid_o && (issue_core_o == CORE_W'(c))),
         .give    (cta_retire_i[c]),
         .need_th (need_th),
         .need_rg (need_rg),
         .need_sm (need_sm),
         .fits    (core_fit[c]),
         .load    (core_load[c*SL_W +: SL_W])
      );
   end

   least_load_pick #(.N(NUM_CORES), .SL_W(SL_W)) u_pick (
      .fits  (core_fit),
      .loads (core_load),
      .found (any_fit),
      .idx   (issue_core_o)
   );

   assign issue_valid_o = busy && (next_id != total) && any_fit;
   assign issue_id_o    = next_id;
   assign grid_done_o   = !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         next_id <= '0;
         total   <= '0;
         need_th <= '0;
         need_rg <= '0;
         need_sm <= '0;
      end else if (!busy) begin
         if (launch_i) begin
            busy    <= 1'b1;
            next_id <= '0;
            total   <= grid_ctas_i;
            need_th <= acc_t'(cta_threads_i);
            need_rg <= acc_t'(cta_threads_i) * acc_t'(thread_regs_i);
            need_sm <= acc_t'(cta_smem_i);
         end
      end else begin
         if (issue_valid_o)
            next_id <= next_id + ID_W'(1);
         if ((next_id == total) && (core_load == '0))
            busy <= 1'b0;
      end
   end
endmodule

// File: rtl/blk_launch_sched_chk.sv
`timescale 1ns/1ps
module blk_launch_sched_chk #(
   parameter int NUM_CORES = 4,
   parameter int MAX_SLOTS = 8,
   parameter int ID_W      = 16,
   parameter int SL_W      = 4,
   parameter int CORE_W    = 2
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      launch_i,
   input logic [NUM_CORES-1:0]      cta_retire_i,
   input logic                      issue_valid_o,
   input logic [CORE_W-1:0]         issue_core_o,
   input logic [ID_W-1:0]           issue_id_o,
   input logic                      grid_done_o,
   input logic [NUM_CORES-1:0]      core_fit,
   input logic [NUM_CORES*SL_W-1:0] core_load
);
   logic [SL_W-1:0] chosen_load;
   assign chosen_load = core_load[issue_core_o*SL_W +: SL_W];

   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      grid_done_o |-> !issue_valid_o);

   p_launch_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
      launch_i && grid_done_o |=> !grid_done_o);

   p_fit_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid_o |-> core_fit[issue_core_o]);

   p_ids_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid_o |=> (!issue_valid_o || issue_id_o == ID_W'($past(issue_id_o) + ID_W'(1))));

   for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
      p_slot_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
         core_load[i*SL_W +: SL_W] <= SL_W'(MAX_SLOTS));

      p_least_r5: assert property (@(posedge clk) disable iff (!rst_n)
         issue_valid_o && core_fit[i] |->
            (chosen_load < core_load[i*SL_W +: SL_W]) ||
            (chosen_load == core_load[i*SL_W +: SL_W] && issue_core_o <= CORE_W'(i)));

      p_retire_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
         cta_retire_i[i] && !(issue_valid_o && issue_core_o == CORE_W'(i)) &&
         core_load[i*SL_W +: SL_W] != '0 |=>
            core_load[i*SL_W +: SL_W] == SL_W'($past(core_load[i*SL_W +: SL_W]) - SL_W'(1)));

      p_net_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
         cta_retire_i[i] && issue_valid_o && issue_core_o == CORE_W'(i) &&
         core_load[i*SL_W +: SL_W] != '0 |=>
            $stable(core_load[i*SL_W +: SL_W]));
   end
endmodule

bind blk_launch_sched blk_launch_sched_chk #(
   .NUM_CORES(NUM_CORES), .MAX_SLOTS(MAX_SLOTS), .ID_W(ID_W),
   .SL_W(SL_W), .CORE_W(CORE_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .launch_i      (launch_i),
   .cta_retire_i  (cta_retire_i),
   .issue_valid_o (issue_valid_o),
   .issue_core_o  (issue_core_o),
   .issue_id_o    (issue_id_o),
   .grid_done_o   (grid_done_o),
   .core_fit      (core_fit),
   .core_load     (core_load)
);

// File: tb/sim_blk_launch_sched.sv
`timescale 1ns/1ps
module sim_blk_launch_sched;
   localparam int NC = 4, LTH = 1024, LRG = 16384, LSM = 16384, LSL = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        launch = 1'b0;
   logic [15:0] ctas = '0;
   logic [10:0] thr = '0;
   logic [7:0]  rpt = '0;
   logic [14:0] smem = '0;
   logic [NC-1:0] retire = '0;
   logic        v_o, d_o;
   logic [1:0]  c_o;
   logic [15:0] id_o;

   always #2 clk = ~clk;   // 250 MHz

   blk_launch_sched u0 (
      .clk(clk), .rst_n(rst_n), .launch_i(launch), .grid_ctas_i(ctas),
      .cta_threads_i(thr), .thread_regs_i(rpt), .cta_smem_i(smem),
      .cta_retire_i(retire), .issue_valid_o(v_o), .issue_core_o(c_o),
      .issue_id_o(id_o), .grid_done_o(d_o)
   );

   int compared = 0, mismatched = 0;
   bit finished = 0;

   // behavioural reference state
   int m_th[NC], m_rg[NC], m_sm[NC], m_cnt[NC];
   bit m_busy = 0;
   int m_next = 0, m_total = 0, n_th = 0, n_rg = 0, n_sm = 0;
   bit e_valid = 0;
   int e_core = 0;

   initial for (int c = 0; c < NC; c++) begin
      m_th[c] = 0; m_rg[c] = 0; m_sm[c] = 0; m_cnt[c] = 0;
   end

   task automatic chk(bit ok, string tag, int act, int exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
      end
   endtask

   // expected outputs for the current cycle, compared mid-cycle
   always @(negedge clk) if (rst_n) begin
      int best;
      e_valid = 0; e_core = 0; best = 0;
      if (m_busy && m_next != m_total)
         for (int c = 0; c < NC; c++)
            if (m_th[c] + n_th <= LTH && m_rg[c] + n_rg <= LRG &&
                m_sm[c] + n_sm <= LSM && m_cnt[c] < LSL &&
                (!e_valid || m_cnt[c] < best)) begin
               e_valid = 1; e_core = c; best = m_cnt[c];
            end
      chk(v_o === e_valid, "R3/R4/R6/R7/R9 issue_valid", int'(v_o), int'(e_valid));
      if (e_valid && v_o) begin
         chk(c_o === 2'(e_core), "R5 issue_core", int'(c_o), e_core);
         chk(id_o === 16'(m_next), "R2/R3 issue_id", int'(id_o), m_next);
      end
      chk(d_o === !m_busy, "R8 grid_done", int'(d_o), int'(!m_busy));
   end

   // reference state update at the edge
   always @(posedge clk) if (rst_n) begin
      if (!m_busy) begin
         if (launch) begin
            m_busy = 1; m_next = 0; m_total = int'(ctas);
            n_th = int'(thr); n_rg = int'(thr) * int'(rpt); n_sm = int'(smem);
         end
      end else begin
         bit idle_all, fin;
         idle_all = 1;
         for (int c = 0; c < NC; c++) if (m_cnt[c] != 0) idle_all = 0;
         fin = (m_next == m_total) && idle_all;
         for (int c = 0; c < NC; c++)
            if (retire[c] && m_cnt[c] > 0) begin
               m_cnt[c]--; m_th[c] -= n_th; m_rg[c] -= n_rg; m_sm[c] -= n_sm;
            end
         if (e_valid) begin
            m_cnt[e_core]++; m_th[e_core] += n_th;
            m_rg[e_core] += n_rg; m_sm[e_core] += n_sm;
            m_next++;
         end
         if (fin) m_busy = 0;
      end
   end

   task automatic step(int n = 1);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic do_launch(int n, int t, int r, int s);
      ctas = 16'(n); thr = 11'(t); rpt = 8'(r); smem = 15'(s);
      launch = 1; step(); launch = 0;
   endtask

   // random retire pulses on busy cores until the grid is done
   task automatic drain(int pct);
      int guard = 0;
      while (!d_o && guard < 5000) begin
         for (int c = 0; c < NC; c++)
            retire[c] = (m_cnt[c] > 0) && (($urandom % 100) < pct);
         step(); guard++;
      end
      retire = '0;
      step(2);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      chk(d_o === 1'b1, "R1 grid_done at reset", int'(d_o), 1);
      chk(v_o === 1'b0, "R1 issue_valid at reset", int'(v_o), 0);
      rst_n = 1;
      step(2);
      chk(d_o === 1'b1 && v_o === 1'b0, "R1 idle after reset", int'(v_o), 0);

      // breadth-first spread, no retirements (R5, R3)
      do_launch(6, 64, 8, 1024);
      step(10);
      drain(50);

      // slot budget: stall at 8 per core, resume after one retire (R4, R9)
      do_launch(40, 32, 4, 256);
      step(45);
      retire = 4'b0100; step(); retire = '0;
      step(3);
      drain(60);

      // thread budget: two blocks of 512 per core (R4, R9)
      do_launch(12, 512, 2, 0);
      step(15);
      drain(30);

      // register budget: 256 x 32 = 8192 per block (R4)
      do_launch(10, 256, 32, 0);
      step(15);
      drain(30);

      // shared-memory budget: 6000 bytes per block (R4)
      do_launch(10, 32, 1, 6000);
      step(15);
      drain(30);

      // empty grid finishes on its own (R8)
      do_launch(0, 64, 1, 0);
      chk(d_o === 1'b0, "R8 done low after launch", int'(d_o), 0);
      step(1);
      chk(d_o === 1'b1, "R8 empty grid done", int'(d_o), 1);
      step(2);

      // relaunch while busy is ignored (R2)
      do_launch(5, 128, 4, 512);
      do_launch(20, 1024, 16, 16384);
      step(6);
      drain(50);

      // stray retire pulses on idle cores are dropped (R6), same-cycle
      // issue and retire on one core (R7)
      do_launch(3, 512, 1, 0);
      step(1);
      retire = 4'b1100; step(); retire = '0;
      step(3);
      drain(50);
      do_launch(30, 64, 1, 0);
      for (int k = 0; k < 40; k++) begin
         retire = 4'b0001 & {3'b000, (m_cnt[0] > 0)};
         step();
      end
      retire = '0;
      drain(50);

      // random grids with retirements during issue (R3, R4, R5, R6, R7, R9)
      for (int g = 0; g < 25; g++) begin
         int t, r, mr;
         t = 1 + int'($urandom % LTH);
         mr = LRG / t; if (mr > 255) mr = 255;
         r = 1 + int'($urandom % mr);
         do_launch(1 + int'($urandom % 60), t, r, int'($urandom % (LSM + 1)));
         drain(35);
      end

      chk(d_o === 1'b1, "R8 final idle", int'(d_o), 1);
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         mismatched++;
         $display("FAIL R8 watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule